// File: doc/BRIEF.md
# Bi-phase-mark event code transmitter

The block serializes 8-bit event codes onto one bi-phase-mark line. While no code is pending the line carries an unbroken run of one cells, which at the nominal 10 Mcell/s rate is a 10 MHz square wave with 50% duty cycle. The block is clocked at twice the cell rate (20 MHz nominal), so every cell is made of two half-cell slots, and the line output comes straight from a register.

A code is handed over with a valid/ready handshake. The block takes it at any clock edge, but the frame always waits for the next cell boundary of the running carrier. A frame is twelve cells: a zero start cell, the eight code bits most significant first, an even-parity cell and two one stop cells. The parity cell covers the start cell as well, so the line leaves the frame in the same phase as the idle carrier. `busy_o` is high, and `ready_o` low, from the accepting edge until the last stop cell has ended.

Top module: `bpm_tx`

## Requirements
- R1: Every cell begins with a level change: the first slot of each cell differs from the last slot of the cell before it.
- R2: A one cell changes level between its two slots; a zero cell keeps the same level in both slots.
- R3: With no frame in flight the line sends one cells, high in the first slot of each cell and low in the second.
- R4: A code is taken on a clock edge where `valid_i` and `ready_o` are both high; `busy_o` is high and `ready_o` low from the next cycle until the second stop cell ends, and both return on the first slot after it.
- R5: The start cell begins at the first cell boundary after the accepting edge; it is preceded by a low half-slot and shows high in both of its slots.
- R6: Cells go out in the order start (0), code bit 7 down to code bit 0, parity, stop (1), stop (1).
- R7: The parity cell makes the count of ones over start, data and parity cells even (parity = XOR of the eight code bits).
- R8: The cell after the second stop cell is an idle one cell, high in its first slot and low in its second.
- R9: While busy, changes on `code_i` and pulses on `valid_i` have no effect on the frame being sent, and no second frame follows unless `valid_i` is high once `ready_o` is back.
- R10: An active-low asynchronous reset drives the line high, selects the first slot of an idle cell, and sets `ready_o` high and `busy_o` low at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the cell rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 8 | Event code to send |
| valid_i | input | 1 | Code on `code_i` is offered |
| ready_o | output | 1 | Block can take a code this cycle |
| busy_o | output | 1 | Frame pending or in flight |
| line_o | output | 1 | Bi-phase-mark line, registered |

## Verification
All 256 codes are sent, alternately offered in the first and the second slot of a cell, so the wait to the next boundary is tried with both one and two slots of latency; a wrong boundary shows as a shifted word. A third of the frames are disturbed by a changed code and a repeated valid pulse while busy, which separates a design that holds its sampled code from one that reads the input live. A held-valid run sends two frames back to back to pin down the single idle cell between them, and a reset in the middle of a frame checks that the line returns to idle phase at once.

// File: rtl/bpm_tx_pkg.sv
package bpm_tx_pkg;

  typedef enum logic {
    SLOT_FIRST  = 1'b0,
    SLOT_SECOND = 1'b1
  } slot_e;

  // start + data + parity + stop
  function automatic int unsigned frame_cells(int unsigned code_w, int unsigned stop_cells);
    return code_w + 2 + stop_cells;
  endfunction

endpackage

// File: rtl/bpm_slot_timer.sv
module bpm_slot_timer
  import bpm_tx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  output slot_e slot_o,
  output logic  cell_edge_o
);

  slot_e slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= SLOT_FIRST;
    else         slot_q <= (slot_q == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
  end

  assign slot_o      = slot_q;
  // next edge opens a new cell
  assign cell_edge_o = (slot_q == SLOT_SECOND);

  AST_SLOT_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> slot_q != $past(slot_q)); // R1

endmodule

// File: rtl/bpm_frame_seq.sv
module bpm_frame_seq
  import bpm_tx_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned STOP_CELLS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_edge_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              cell_bit_o
);

  localparam int unsigned FRAME_W = frame_cells(CODE_W, STOP_CELLS);
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam int unsigned PAR_POS = STOP_CELLS;

  logic [FRAME_W-1:0] frame_d, frame_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, bit_q, accept;

  always_comb begin
    frame_d            = '0;
    frame_d[FRAME_W-1] = 1'b0;
    for (int i = 0; i < int'(CODE_W); i++) begin
      frame_d[FRAME_W-2-i] = code_i[CODE_W-1-i];
    end
    frame_d[PAR_POS] = ^code_i;
    for (int s = 0; s < int'(STOP_CELLS); s++) begin
      frame_d[s] = 1'b1;
    end
  end

  assign accept = valid_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      bit_q   <= 1'b1;
    end else if (accept) begin
      frame_q <= frame_d;
      cnt_q   <= CNT_W'(FRAME_W);
      busy_q  <= 1'b1;
    end else if (cell_edge_i) begin
      if (cnt_q != '0) begin
        bit_q   <= frame_q[FRAME_W-1];
        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        cnt_q   <= cnt_q - CNT_W'(1);
      end else begin
        bit_q  <= 1'b1;
        busy_q <= 1'b0;
      end
    end
  end

  assign ready_o    = ~busy_q;
  assign busy_o     = busy_q;
  assign cell_bit_o = bit_q;

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> busy_o); // R4
  AST_START_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_edge_i && busy_q && cnt_q == CNT_W'(FRAME_W) |=> !bit_q); // R6
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_W)); // R6
  AST_IDLE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> bit_q); // R3
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !cell_edge_i |=> $stable(frame_q)); // R9

endmodule

// File: rtl/bpm_line_enc.sv
module bpm_line_enc
  import bpm_tx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  slot_e slot_i,
  input  logic  cell_bit_i,
  output logic  line_o
);

  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   line_q <= 1'b1;
    else if (slot_i == SLOT_SECOND) line_q <= ~line_q;           // cell boundary
    else                           line_q <= line_q ^ cell_bit_i; // mid-cell
  end

  assign line_o = line_q;

  AST_EDGE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i == SLOT_SECOND |=> line_q != $past(line_q)); // R1
  AST_MID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i == SLOT_FIRST && cell_bit_i |=> line_q != $past(line_q)); // R2
  AST_MID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i == SLOT_FIRST && !cell_bit_i |=> $stable(line_q)); // R2

endmodule

// File: rtl/bpm_tx.sv
module bpm_tx
  import bpm_tx_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned STOP_CELLS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              line_o
);

  slot_e slot;
  logic  cell_edge, cell_bit;

  bpm_slot_timer u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_o      (slot),
    .cell_edge_o (cell_edge)
  );

  bpm_frame_seq #(
    .CODE_W     (CODE_W),
    .STOP_CELLS (STOP_CELLS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cell_edge_i (cell_edge),
    .code_i      (code_i),
    .valid_i     (valid_i),
    .ready_o     (ready_o),
    .busy_o      (busy_o),
    .cell_bit_o  (cell_bit)
  );

  bpm_line_enc u_enc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_i     (slot),
    .cell_bit_i (cell_bit),
    .line_o     (line_o)
  );

  AST_IDLE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && slot == SLOT_FIRST |-> line_o); // R8
  AST_IDLE_LOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && slot == SLOT_SECOND && !$past(busy_o) |-> !line_o); // R3

endmodule

// File: tb/bpm_tx_test.sv
module bpm_tx_test;

  localparam int CLK_PERIOD = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] code = '0;
  logic       valid = 1'b0;
  logic       ready, busy, line;

  int checks = 0;
  int fails  = 0;
  int slot;
  bit done   = 1'b0;
  logic lv [0:63];
  logic bz [0:63];

  bpm_tx uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .code_i  (code),
    .valid_i (valid),
    .ready_o (ready),
    .busy_o  (busy),
    .line_o  (line)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // bench's own slot count since reset release; even = first half of a cell
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= 0;
    else        slot <= slot + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic logic [11:0] exp_word(input logic [7:0] c);
    return {1'b0, c, ^c, 2'b11};
  endfunction

  function automatic logic [11:0] decode(input int o);
    logic [11:0] w;
    for (int c = 0; c < 12; c++) w[11-c] = lv[o+2*c] ^ lv[o+2*c+1];
    return w;
  endfunction

  function automatic bit bounds_ok(input int o);
    for (int c = 0; c < 13; c++) if (lv[o+2*c] == lv[o+2*c-1]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic wait_offer(input int p);
    while (!(ready && (slot % 2) == p)) tick;
  endtask

  task automatic send_frame(input logic [7:0] c, input int p, input bit disturb);
    int o;
    logic [11:0] w;
    bit bz_ok;
    wait_offer(p);
    o = ((slot % 2) == 0) ? 1 : 2;
    code = c; valid = 1'b1;
    tick;
    valid = 1'b0;
    code = ~c;
    for (int i = 0; i < 30; i++) begin
      lv[i] = line; bz[i] = busy;
      if (disturb && i == 3)  begin valid = 1'b1; code = c ^ 8'h5a; end
      if (disturb && i == 15) valid = 1'b0;
      tick;
    end
    w = decode(o);
    chk(w == exp_word(c), "R6 R2 R9 word", int'(w), int'(exp_word(c)));
    chk(^w[11:2] == 1'b0, "R7 parity", int'(w[2]), int'(^c));
    chk(bounds_ok(o), "R1 boundaries", int'(o), 1);
    chk(lv[o-1] == 1'b0 && lv[o] == 1'b1 && lv[o+1] == 1'b1, "R5 start position",
        int'({lv[o-1], lv[o], lv[o+1]}), 3);
    chk(lv[o+24] == 1'b1 && lv[o+25] == 1'b0, "R8 idle after", int'({lv[o+24], lv[o+25]}), 2);
    bz_ok = 1'b1;
    for (int i = 0; i < o + 24; i++) if (bz[i] !== 1'b1) bz_ok = 1'b0;
    chk(bz_ok && bz[o+24] == 1'b0, "R4 busy window", int'(bz[o+24]), 0);
    if (disturb) chk(bz[o+25] == 1'b0 && bz[o+26] == 1'b0, "R9 no extra frame",
                     int'({bz[o+25], bz[o+26]}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 160000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // reset state R10
    #(CLK_PERIOD * 2 + 10);
    chk(line == 1'b1 && ready == 1'b1 && busy == 1'b0, "R10 reset state",
        int'({line, ready, busy}), 6);
    tick;
    rst_n = 1'b1;
    // idle carrier R3
    for (int i = 0; i < 8; i++) begin
      chk(line == ((slot % 2) == 0), "R3 idle carrier", int'(line), int'((slot % 2) == 0));
      tick;
    end

    // sweep every code, both offer phases, a third disturbed
    for (int c = 0; c < 256; c++) send_frame(8'(c), c % 2, (c % 3) == 0);

    // back to back with valid held: one idle cell between frames R4 R5
    begin
      logic [11:0] w;
      wait_offer(0);
      code = 8'ha5; valid = 1'b1;
      tick;
      code = 8'h3c;
      for (int i = 0; i < 60; i++) begin
        lv[i] = line; bz[i] = busy;
        if (i == 26) valid = 1'b0;
        tick;
      end
      w = decode(1);
      chk(w == exp_word(8'ha5), "R6 first of pair", int'(w), int'(exp_word(8'ha5)));
      chk(bz[25] == 1'b0 && bz[26] == 1'b1, "R4 ready gap", int'({bz[25], bz[26]}), 1);
      chk(lv[25] == 1'b1 && lv[26] == 1'b0, "R5 idle cell between", int'({lv[25], lv[26]}), 2);
      w = decode(27);
      chk(w == exp_word(8'h3c), "R5 second of pair", int'(w), int'(exp_word(8'h3c)));
      chk(bounds_ok(27), "R1 second of pair", 0, 1);
    end

    // reset in mid frame R10
    wait_offer(0);
    code = 8'h00; valid = 1'b1;
    tick;
    valid = 1'b0;
    repeat (9) tick;
    #5 rst_n = 1'b0;
    #1;
    chk(line == 1'b1 && ready == 1'b1 && busy == 1'b0, "R10 async reset",
        int'({line, ready, busy}), 6);
    tick;
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      chk(line == ((slot % 2) == 0) && busy == 1'b0, "R3 idle after reset",
          int'(line), int'((slot % 2) == 0));
      tick;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule